// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block links a synchronous host request port to one or more external asynchronous SRAM devices, each 256K words by 16 bits. It is built for a 200 MHz clock, so one cycle lasts 5 ns. Every access, read or write, takes exactly four cycles (20 ns). Accesses can follow each other with no gap, which is fast enough to keep a 25 MHz pixel stream fed.

The host offers a request as an address, write data and a write flag, qualified by `req_valid`. The block takes a request at a rising edge when it is idle (`ready` high) or when it is in the last cycle of an access (`done` high). The devices share the address, output-enable and write-enable lines. Each device has its own chip select, picked by the top bits of the host address. The data bus is split into an output, an output-enable and an input, which a pad tristate joins. All SRAM-facing outputs come from flops.

Top module: `sram_ctrl`

## Requirements
- R1: While `rst` is high, `ready` is 1, `done` is 0, every bit of `sram_ce_n` is 1, `sram_oe_n` and `sram_we_n` are 1, and `sram_dq_oe` is 0.
- R2: A request is taken at a rising edge where `req_valid` is high and either `ready` or `done` is high. `ready` is high only when no access is in progress. A request taken while `done` is high starts its access in the very next cycle, so back-to-back `done` pulses are exactly 4 cycles apart.
- R3: Each access lasts four cycles. `done` is high for one cycle only: the fourth cycle after the edge that took the request.
- R4: During a read, `sram_we_n` stays 1, and `sram_oe_n` is 0 for the first three access cycles and 1 in the fourth.
- R5: Read data is sampled from `sram_dq_i` at the end of the third access cycle. It is shown on `rd_data` while `done` is high.
- R6: During a write, `sram_oe_n` stays 1 and `sram_dq_oe` is 1 for all four access cycles. `sram_we_n` is 0 in cycles two and three only, so the data is still driven in the cycle after `sram_we_n` rises.
- R7: `sram_dq_oe` is never 1 in a cycle where `sram_oe_n` is 0.
- R8: The top host address bit (value d) selects the device. During an access exactly `sram_ce_n[d]` is 0. With no access in progress, no chip select is 0. The 18 lower host address bits appear on `sram_addr`.
- R9: `sram_addr` does not change between the cycles of one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Device select bit followed by 18-bit word address |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | Idle, request can be taken |
| done | output | 1 | Last cycle of an access; request can be taken |
| rd_data | output | 16 | Read result, valid with `done` after a read |
| sram_addr | output | 18 | Shared SRAM address |
| sram_ce_n | output | 2 | Active-low chip select per device |
| sram_oe_n | output | 1 | Shared active-low output enable |
| sram_we_n | output | 1 | Shared active-low write enable |
| sram_dq_o | output | 16 | Data toward the SRAM |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_o` |
| sram_dq_i | input | 16 | Data from the SRAM |

## Verification
If a request is taken at edge N, the pins change after edge N, the read sample is taken at edge N+3, and `done` with `rd_data` is seen after edge N+3. The scoreboard records the cycle count at the taking edge and checks that the matching `done` arrives exactly three counted edges later. In a burst it also checks that successive `done` pulses are four cycles apart. The SRAM model in the bench drives valid read data only from the third cycle of output enable onward, so a sample taken earlier returns a marker value and fails the data compare. All pin sampling happens on falling edges, halfway between the edges that update the flops.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  // Access phases: one idle state plus four 5 ns phases per access
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } acc_state_e;
endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int HADDR_W = 19,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [HADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output acc_state_e         state_q,
  output acc_state_e         state_d,
  output logic               wr_q,
  output logic               wr_d,
  output logic [HADDR_W-1:0] addr_d,
  output logic [DATA_W-1:0]  wdata_d
);
  logic [HADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               take;

  // A request is taken when idle or in the final access phase
  assign take = req_valid && ((state_q == ST_IDLE) || (state_q == ST_T4));

  always_comb begin
    state_d = state_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    unique case (state_q)
      ST_IDLE: if (take) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3:   state_d = ST_T4;
      ST_T4:   state_d = take ? ST_T1 : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (take) begin
      wr_d    = req_write;
      addr_d  = req_addr;
      wdata_d = req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end
endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int NUM_DEV = 2,
  parameter int DEV_W   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  acc_state_e         state_d,
  input  logic               wr_d,
  input  logic [ADDR_W-1:0]  waddr_d,
  input  logic [DEV_W-1:0]   dev_d,
  input  logic [DATA_W-1:0]  wdata_d,
  output logic [ADDR_W-1:0]  sram_addr,
  output logic [NUM_DEV-1:0] sram_ce_n,
  output logic               sram_oe_n,
  output logic               sram_we_n,
  output logic [DATA_W-1:0]  sram_dq_o,
  output logic               sram_dq_oe
);
  logic active, rd_win, we_win;

  // Pins are registered from the next phase so they are glitch-free
  assign active = (state_d != ST_IDLE);
  assign rd_win = active && !wr_d && (state_d != ST_T4);
  assign we_win = wr_d && ((state_d == ST_T2) || (state_d == ST_T3));

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_ce
    always_ff @(posedge clk) begin
      if (rst) sram_ce_n[d] <= 1'b1;
      else     sram_ce_n[d] <= !(active && (dev_d == DEV_W'(d)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr  <= '0;
      sram_oe_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_dq_o  <= '0;
      sram_dq_oe <= 1'b0;
    end else begin
      sram_addr  <= waddr_d;
      sram_oe_n  <= !rd_win;
      sram_we_n  <= !we_win;
      sram_dq_o  <= wdata_d;
      sram_dq_oe <= active && wr_d;
    end
  end
endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap
  import sram_ctrl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_state_e        state_q,
  input  acc_state_e        state_d,
  input  logic              wr_q,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      done    <= 1'b0;
      ready   <= 1'b1;
    end else begin
      // Sample after three phases of output enable (access time met)
      if ((state_q == ST_T3) && !wr_q) rd_data <= sram_dq_i;
      done  <= (state_d == ST_T4);
      ready <= (state_d == ST_IDLE);
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int NUM_DEV = 2,
  localparam int DEV_W   = $clog2(NUM_DEV),
  localparam int HADDR_W = ADDR_W + DEV_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [HADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               ready,
  output logic               done,
  output logic [DATA_W-1:0]  rd_data,
  output logic [ADDR_W-1:0]  sram_addr,
  output logic [NUM_DEV-1:0] sram_ce_n,
  output logic               sram_oe_n,
  output logic               sram_we_n,
  output logic [DATA_W-1:0]  sram_dq_o,
  output logic               sram_dq_oe,
  input  logic [DATA_W-1:0]  sram_dq_i
);
  acc_state_e         state_q, state_d;
  logic               wr_q, wr_d;
  logic [HADDR_W-1:0] addr_d;
  logic [DATA_W-1:0]  wdata_d;

  sram_ctrl_seq #(.HADDR_W(HADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .state_q(state_q), .state_d(state_d),
    .wr_q(wr_q), .wr_d(wr_d),
    .addr_d(addr_d), .wdata_d(wdata_d)
  );

  sram_ctrl_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DEV(NUM_DEV), .DEV_W(DEV_W)
  ) u_pins (
    .clk(clk), .rst(rst),
    .state_d(state_d), .wr_d(wr_d),
    .waddr_d(addr_d[ADDR_W-1:0]),
    .dev_d(addr_d[HADDR_W-1:ADDR_W]),
    .wdata_d(wdata_d),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe)
  );

  sram_ctrl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk(clk), .rst(rst),
    .state_q(state_q), .state_d(state_d), .wr_q(wr_q),
    .sram_dq_i(sram_dq_i),
    .rd_data(rd_data), .done(done), .ready(ready)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W  = 18,
  parameter int NUM_DEV = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               ready,
  input logic               done,
  input logic [ADDR_W-1:0]  sram_addr,
  input logic [NUM_DEV-1:0] sram_ce_n,
  input logic               sram_oe_n,
  input logic               sram_we_n,
  input logic               sram_dq_oe
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~sram_ce_n)); // R8

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !(sram_dq_oe && !sram_oe_n)); // R7

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    ready |-> (&sram_ce_n)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3

  AST_READ_NO_WE: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> sram_we_n); // R4

  AST_WE_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> sram_dq_oe); // R6

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!(&sram_ce_n) && !done) |=> $stable(sram_addr)); // R9
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .done(done),
  .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
  .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dq_oe(sram_dq_oe)
);

// File: tb/sram_ctrl_test.sv
`timescale 1ns/1ps
module sram_ctrl_test;
  localparam int ADDR_W = 18;
  localparam int DATA_W = 16;
  localparam int NUM_DEV = 2;
  localparam int HADDR_W = 19;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, req_valid, req_write, ready, done;
  logic [HADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, rd_data, sram_dq_o, sram_dq_i;
  logic [ADDR_W-1:0] sram_addr;
  logic [NUM_DEV-1:0] sram_ce_n;
  logic sram_oe_n, sram_we_n, sram_dq_oe;

  sram_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
    .rd_data(rd_data), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {bit wr; logic [15:0] exp; int acc; bit gap;} item_t;
  item_t sb[$];
  logic [15:0] mem [int];

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Driver: present a request and push the expected result on acceptance
  task automatic issue(bit wr, logic [18:0] a, logic [15:0] d, bit gap);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!(ready || done)) @(negedge clk);
    @(posedge clk); #1;
    sb.push_back('{wr, d, cyc, gap});
  endtask

  task automatic rest(int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // SRAM model and pin monitors, sampled on falling edges
  int oe_run = 0, we_run = 0, contention = 0, rdy_busy = 0, both_ce = 0, addr_moves = 0;
  logic prev_act = 1'b0, prev_done = 1'b0, prev_we = 1'b1;
  logic [ADDR_W-1:0] prev_addr = '0;
  int last_done = 0;

  function automatic int key_of();
    return (sram_ce_n[0] ? (1 << ADDR_W) : 0) + int'(sram_addr);
  endfunction

  initial sram_dq_i = 16'h0BAD;

  always @(negedge clk) begin
    if (!rst) begin
      logic act;
      act = !(&sram_ce_n);
      if (sram_dq_oe && !sram_oe_n) contention++;
      if (ready && act) rdy_busy++;
      if (sram_ce_n == '0) both_ce++;
      if (prev_act && !prev_done && act && sram_addr != prev_addr) addr_moves++;
      // Output enable window and access-time model
      if (!sram_oe_n && act) begin
        oe_run++;
        sram_dq_i = (oe_run >= 3 && mem.exists(key_of())) ? mem[key_of()] : 16'h0BAD;
      end else begin
        if (oe_run != 0) check(oe_run == 3, "R4", "oe_n low cycles", oe_run, 3);
        oe_run = 0;
        sram_dq_i = 16'h0BAD;
      end
      // Write strobe: store on rising we_n, data must still be driven
      if (!sram_we_n) we_run++;
      else if (!prev_we) begin
        check(we_run == 2, "R6", "we_n low cycles", we_run, 2);
        check(sram_dq_oe == 1'b1, "R6", "data held after we_n rise", sram_dq_oe, 1);
        if (act) mem[key_of()] = sram_dq_o;
        we_run = 0;
      end
      prev_we = sram_we_n;
      prev_act = act; prev_done = done; prev_addr = sram_addr;
    end
  end

  // Monitor: pop scoreboard items on each done pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) check(1'b0, "R3", "unexpected done", 1, 0);
      else begin
        item_t it;
        it = sb.pop_front();
        check(cyc == it.acc + 3, "R3", "done latency", cyc - it.acc, 3);
        if (!it.wr) check(rd_data == it.exp, "R5", "read data", rd_data, it.exp);
        if (it.gap) check(cyc - last_done == 4, "R2", "back-to-back spacing", cyc - last_done, 4);
      end
      last_done = cyc;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "WATCHDOG", "run hung", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ready == 1'b1, "R1", "ready in reset", ready, 1);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(sram_ce_n == 2'b11, "R1", "ce_n in reset", sram_ce_n, 3);
    check(sram_oe_n && sram_we_n, "R1", "oe_n/we_n in reset", {sram_oe_n, sram_we_n}, 3);
    check(sram_dq_oe == 1'b0, "R1", "dq_oe in reset", sram_dq_oe, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R8: same word address on both devices, plus the top word
    issue(1'b1, {1'b0, 18'h00010}, 16'h1234, 1'b0);
    issue(1'b1, {1'b1, 18'h00010}, 16'hABCD, 1'b1);
    issue(1'b1, {1'b0, 18'h3FFFF}, 16'h5A5A, 1'b1);
    issue(1'b1, {1'b1, 18'h3FFFF}, 16'hC3C3, 1'b1);
    rest(3);
    // Back-to-back reads (R2, R5, R8)
    issue(1'b0, {1'b0, 18'h00010}, 16'h1234, 1'b0);
    issue(1'b0, {1'b1, 18'h00010}, 16'hABCD, 1'b1);
    issue(1'b0, {1'b0, 18'h3FFFF}, 16'h5A5A, 1'b1);
    issue(1'b0, {1'b1, 18'h3FFFF}, 16'hC3C3, 1'b1);
    rest(2);
    // Read straight after write of the same word
    issue(1'b1, {1'b0, 18'h00020}, 16'h1111, 1'b0);
    issue(1'b0, {1'b0, 18'h00020}, 16'h1111, 1'b1);
    rest(1);
    // Overwrite one device, the other keeps its word (R8)
    issue(1'b1, {1'b0, 18'h00010}, 16'h7777, 1'b0);
    rest(4);
    issue(1'b0, {1'b0, 18'h00010}, 16'h7777, 1'b0);
    issue(1'b0, {1'b1, 18'h00010}, 16'hABCD, 1'b1);
    rest(6);

    check(sb.size() == 0, "R3", "outstanding accesses", sb.size(), 0);
    check(contention == 0, "R7", "drive with oe_n low", contention, 0);
    check(rdy_busy == 0, "R2", "ready during access", rdy_busy, 0);
    check(both_ce == 0, "R8", "two chip selects low", both_ce, 0);
    check(addr_moves == 0, "R9", "address change inside access", addr_moves, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule